// File: doc/BRIEF.md
# SPI ADC Channel Read Sequencer

This block performs one complete channel read from an external 12-bit, 16-input successive-approximation converter attached over a four-wire SPI link. A host hands over a channel number through a valid/ready request port. The block then talks to the converter in two chip-select framed 16-bit transfers. The first transfer loads the converter's control register with the channel-select word, and the data returned during it is thrown away. The chip select then stays high for a programmable quiet gap. The second transfer shifts out an all-zero word, which leaves the converter's control register untouched, and captures the conversion result on MISO.

A request is accepted in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A request presented while the block is busy is not taken and leaves no trace. The response side has no back-pressure. `done` pulses for one cycle, and `rd_data`/`rd_err` then hold their values until the next `done`. A channel number of 12 or more is refused. The block raises the error flag and runs no SPI traffic.

The SCLK half period is `SCLK_HALF_DIV` system clocks. The default of 11 at a 250 MHz system clock gives about 11.4 MHz, which stays below the 12 MHz limit. The quiet gap is `QUIET_CYCLES` system clocks, and its default of 250 is 1 us at 250 MHz.

Top module: `adc_chan_reader`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_mosi` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the read completes, and requests offered while it is low cause no extra frame and no extra `done`.
- R3: Each frame is 16 SCLK cycles in SPI mode 0. SCLK is low whenever chip select is high and idles low. MOSI changes on falling edges, is shifted MSB first and is sampled on rising edges. MOSI is 0 while chip select is high.
- R4: Each SCLK high or low phase lasts at least `SCLK_HALF_DIV` clocks. Chip select falls at least one half period before the first rising edge and rises at least one half period after the last falling edge.
- R5: The first frame's MOSI word is {control[11:0], 4'b0000}. The control field has bit 11 = 1 (write), bits 9:6 = channel, bit 10 = 0, bits 5 and 4 = 1, bits 3 and 2 = 0, and bits 1 and 0 = 1. For channel c this is 16'h8330 | (c << 10).
- R6: The second frame's MOSI word is 16'h0000. MISO data captured during the first frame never reaches `rd_data`.
- R7: Between the first and second frame of one read, chip select stays high for at least `QUIET_CYCLES` clocks.
- R8: `rd_data` is bits 11:0 of the 16-bit word received MSB first on MISO during the second frame. Bits 15:12 are discarded.
- R9: A request with channel 12 or above produces no chip-select activity. It produces one `done` pulse with `rd_err` = 1 and leaves `rd_data` unchanged. A valid read sets `rd_err` to 0.
- R10: `done` is high for exactly one cycle per accepted request, and `rd_data` and `rd_err` do not change except in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_chan | input | 4 | Channel to read, valid range 0 to 11 |
| done | output | 1 | One-cycle completion strobe |
| rd_err | output | 1 | Last request had an out-of-range channel |
| rd_data | output | 12 | Last conversion result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | SPI clock, mode 0 |
| adc_mosi | output | 1 | Serial data to converter |
| adc_miso | input | 1 | Serial data from converter |

## Verification
The properties assume that `adc_miso` is stable around every SCLK rising edge and that reset lasts at least one clock. The property for R7 also assumes that frames always come in pairs, which holds as long as reset is never applied in the middle of a read. The property for R10 assumes nothing about the host. It only requires that the host never needs back-pressure on the response. The bench's converter model changes MISO only at chip-select fall and at SCLK falling edges, many system clocks away from the sampling edge. The driver changes request pins only on the falling system clock, and it offers requests during busy periods deliberately so that those requests must be refused.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  // fixed layout of the converter's serial protocol
  localparam int unsigned FRAME_W   = 16;
  localparam int unsigned CTRL_W    = 12;
  localparam int unsigned DATA_W    = 12;
  localparam int unsigned CHAN_W    = 4;
  localparam int unsigned NUM_CHAN  = 12;
  // control field bit positions, decoded by the converter
  localparam int unsigned F_WE      = 11;
  localparam int unsigned F_CH_LSB  = 6;
  localparam int unsigned F_PWR1    = 5;
  localparam int unsigned F_PWR0    = 4;
  localparam int unsigned F_SPAN    = 1;
  localparam int unsigned F_BIN     = 0;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FRAME1,
    SQ_GAP,
    SQ_FRAME2
  } seq_state_e;

  function automatic logic [FRAME_W-1:0] build_ctrl(input logic [CHAN_W-1:0] ch);
    logic [CTRL_W-1:0] c;
    c = '0;
    c[F_WE] = 1'b1;
    c[F_CH_LSB +: CHAN_W] = ch;
    c[F_PWR1] = 1'b1;
    c[F_PWR0] = 1'b1;
    c[F_SPAN] = 1'b1;
    c[F_BIN] = 1'b1;
    return {c, {(FRAME_W-CTRL_W){1'b0}}};
  endfunction
endpackage

// File: rtl/adc_spi_engine.sv
// One chip-select framed mode-0 transfer, MSB first.
module adc_spi_engine #(
  parameter int unsigned HALF_DIV = 11,
  parameter int unsigned BITS     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [BITS-1:0] tx_word,
  input  logic            miso,
  output logic            cs_n,
  output logic            sclk,
  output logic            mosi,
  output logic [BITS-1:0] rx_word,
  output logic            fin
);
  localparam int unsigned TICKS = 2 * BITS;
  localparam int unsigned TK_W  = $clog2(TICKS + 1);
  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);

  logic            run;
  logic [DIV_W-1:0] div;
  logic [TK_W-1:0]  tick;
  logic [BITS-1:0]  tx_sh;
  logic [BITS-1:0]  rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cs_n  <= 1'b1;
      sclk  <= 1'b0;
      div   <= '0;
      tick  <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!run) begin
        if (go) begin
          run   <= 1'b1;
          cs_n  <= 1'b0;
          tx_sh <= tx_word;
          div   <= '0;
          tick  <= '0;
        end
      end else if (div == DIV_W'(HALF_DIV - 1)) begin
        div <= '0;
        if (tick == TK_W'(TICKS)) begin
          run   <= 1'b0;
          cs_n  <= 1'b1;
          fin   <= 1'b1;
          tx_sh <= '0;
        end else begin
          tick <= tick + TK_W'(1);
          if (!tick[0]) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[BITS-2:0], miso};
          end else begin
            sclk  <= 1'b0;
            tx_sh <= {tx_sh[BITS-2:0], 1'b0};
          end
        end
      end else begin
        div <= div + DIV_W'(1);
      end
    end
  end

  assign mosi    = tx_sh[BITS-1];
  assign rx_word = rx_sh;
endmodule

// File: rtl/adc_gap_timer.sv
// Counts the chip-select quiet time between the two frames.
module adc_gap_timer #(
  parameter int unsigned QUIET = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic fin
);
  localparam int unsigned CW = $clog2(QUIET + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        cnt <= CW'(QUIET);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_chan_reader.sv
module adc_chan_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned SCLK_HALF_DIV = 11,
  parameter int unsigned QUIET_CYCLES  = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CHAN_W-1:0] req_chan,
  output logic              done,
  output logic              rd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_mosi,
  input  logic              adc_miso
);
  seq_state_e         st;
  logic               accept;
  logic               chan_ok;
  logic               eng_go;
  logic               eng_fin;
  logic [FRAME_W-1:0] eng_tx;
  logic [FRAME_W-1:0] eng_rx;
  logic               gap_go;
  logic               gap_fin;

  assign req_ready = (st == SQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign chan_ok   = (req_chan < CHAN_W'(NUM_CHAN));
  assign eng_go    = (accept && chan_ok) || (st == SQ_GAP && gap_fin);
  assign eng_tx    = (st == SQ_IDLE) ? build_ctrl(req_chan) : '0;
  assign gap_go    = (st == SQ_FRAME1) && eng_fin;

  adc_spi_engine #(
    .HALF_DIV(SCLK_HALF_DIV),
    .BITS    (FRAME_W)
  ) u_spi (
    .clk    (clk),
    .rst    (rst),
    .go     (eng_go),
    .tx_word(eng_tx),
    .miso   (adc_miso),
    .cs_n   (adc_cs_n),
    .sclk   (adc_sclk),
    .mosi   (adc_mosi),
    .rx_word(eng_rx),
    .fin    (eng_fin)
  );

  adc_gap_timer #(
    .QUIET(QUIET_CYCLES)
  ) u_gap (
    .clk(clk),
    .rst(rst),
    .go (gap_go),
    .fin(gap_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      done    <= 1'b0;
      rd_err  <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (accept) begin
            if (chan_ok) begin
              st <= SQ_FRAME1;
            end else begin
              done   <= 1'b1;
              rd_err <= 1'b1;
            end
          end
        end
        SQ_FRAME1: if (eng_fin) st <= SQ_GAP;
        SQ_GAP:    if (gap_fin) st <= SQ_FRAME2;
        SQ_FRAME2: begin
          if (eng_fin) begin
            st      <= SQ_IDLE;
            done    <= 1'b1;
            rd_err  <= 1'b0;
            rd_data <= eng_rx[DATA_W-1:0];
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_chan_reader_chk.sv
module adc_chan_reader_chk #(
  parameter int unsigned SCLK_HALF_DIV = 11,
  parameter int unsigned QUIET_CYCLES  = 250
) (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        done,
  input logic        rd_err,
  input logic [11:0] rd_data,
  input logic        adc_cs_n,
  input logic        adc_sclk,
  input logic        adc_mosi
);
  localparam int unsigned HW = $clog2(SCLK_HALF_DIV + 1);
  localparam int unsigned QW = $clog2(QUIET_CYCLES + 1);

  logic          sclk_q;
  logic [HW-1:0] hold;
  logic          cs_q;
  logic [QW-1:0] hi_cnt;
  logic          odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      hold   <= HW'(SCLK_HALF_DIV);
      cs_q   <= 1'b1;
      hi_cnt <= QW'(QUIET_CYCLES);
      odd    <= 1'b0;
    end else begin
      sclk_q <= adc_sclk;
      if (adc_sclk != sclk_q) hold <= HW'(1);
      else if (hold != HW'(SCLK_HALF_DIV)) hold <= hold + HW'(1);
      cs_q <= adc_cs_n;
      if (!adc_cs_n) hi_cnt <= '0;
      else if (hi_cnt != QW'(QUIET_CYCLES)) hi_cnt <= hi_cnt + QW'(1);
      if (cs_q && !adc_cs_n) odd <= ~odd;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (adc_cs_n && !adc_sclk && !adc_mosi && !done && req_ready)); // R1
  AST_NO_ACCEPT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n |-> !req_ready); // R2
  AST_SCLK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    adc_sclk |-> !adc_cs_n); // R3
  AST_MOSI_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !adc_mosi); // R3
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (adc_sclk != sclk_q) |-> (hold >= HW'(SCLK_HALF_DIV))); // R4
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_cs_n) && odd) |-> (hi_cnt >= QW'(QUIET_CYCLES))); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rd_data) && $stable(rd_err))); // R10
endmodule

bind adc_chan_reader adc_chan_reader_chk #(
  .SCLK_HALF_DIV(SCLK_HALF_DIV),
  .QUIET_CYCLES (QUIET_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .done     (done),
  .rd_err   (rd_err),
  .rd_data  (rd_data),
  .adc_cs_n (adc_cs_n),
  .adc_sclk (adc_sclk),
  .adc_mosi (adc_mosi)
);

// File: tb/tb_adc_chan_reader.sv
`timescale 1ns/1ps
module tb_adc_chan_reader;
  localparam int HALF  = 11;
  localparam int QUIET = 250;
  localparam realtime TCLK = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_chan = '0;
  logic        req_ready, done, rd_err;
  logic [11:0] rd_data;
  logic        adc_cs_n, adc_sclk, adc_mosi;
  logic        adc_miso = 1'b0;

  always #2 clk = ~clk;

  adc_chan_reader #(.SCLK_HALF_DIV(HALF), .QUIET_CYCLES(QUIET)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .done(done), .rd_err(rd_err), .rd_data(rd_data),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_mosi(adc_mosi),
    .adc_miso(adc_miso)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sample(input int ch, input int k);
    if (k == 3) return 12'hFFF;
    if (k == 4) return 12'h000;
    return 12'(ch * 419 + k * 247 + 92);
  endfunction

  // ---------------- converter model ----------------
  logic [15:0] m_tx, m_rx;
  logic [3:0]  m_ch = '0;
  int          m_bits = 0, m_frames = 0, m_conv = 0;
  bit          in_frame = 0, first_rise = 0;
  realtime     t_fall, t_rise_cs, t_last_rise, t_last_fall;
  logic [15:0] word_q[$];

  always @(negedge adc_cs_n) begin
    t_fall = $realtime;
    if (m_frames % 2 == 1)
      check(t_fall - t_rise_cs >= QUIET * TCLK, "R7 quiet gap",
            int'((t_fall - t_rise_cs) / TCLK), QUIET);
    in_frame = 1; first_rise = 1; m_bits = 0; m_rx = '0;
    m_tx = (m_frames % 2 == 1) ? {4'hE, sample(m_ch, m_conv)} : 16'hFACE;
    adc_miso = m_tx[15];
  end

  always @(posedge adc_sclk) begin
    if (first_rise)
      check($realtime - t_fall >= HALF * TCLK, "R4 cs setup",
            int'(($realtime - t_fall) / TCLK), HALF);
    else if ($realtime - t_last_rise < 2 * HALF * TCLK)
      check(0, "R4 sclk period", int'(($realtime - t_last_rise) / TCLK), 2 * HALF);
    first_rise = 0;
    t_last_rise = $realtime;
    m_rx = {m_rx[14:0], adc_mosi};
    m_bits++;
  end

  always @(negedge adc_sclk) begin
    t_last_fall = $realtime;
    m_tx = {m_tx[14:0], 1'b0};
    adc_miso = m_tx[15];
  end

  always @(posedge adc_cs_n) begin
    if (in_frame) begin
      in_frame = 0;
      t_rise_cs = $realtime;
      check(m_bits == 16, "R3 bits per frame", m_bits, 16);
      check($realtime - t_last_fall >= HALF * TCLK, "R4 cs hold",
            int'(($realtime - t_last_fall) / TCLK), HALF);
      word_q.push_back(m_rx);
      if (m_frames % 2 == 0) begin
        if (m_rx[15]) m_ch = m_rx[13:10];
      end else begin
        m_conv++;
      end
      m_frames++;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic        err;
    logic [11:0] data;
    logic [3:0]  ch;
  } exp_t;
  exp_t exp_q[$];
  int   drv_conv = 0;
  logic [11:0] last_data = '0;
  logic        last_err = 1'b0;
  bit          have_prev = 0;
  int          extra_done = 0;

  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        extra_done++;
        check(0, "R2 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rd_err == e.err, "R9 error flag", rd_err, e.err);
        check(rd_data == e.data, "R8 result", rd_data, e.data);
        if (e.err) begin
          check(word_q.size() == 0, "R9 no frames on bad channel", word_q.size(), 0);
        end else begin
          check(word_q.size() == 2, "R2 two frames per read", word_q.size(), 2);
          if (word_q.size() == 2) begin
            logic [15:0] w1, w2, ex;
            w1 = word_q.pop_front();
            w2 = word_q.pop_front();
            ex = 16'h8330 | (16'(e.ch) << 10);
            check(w1 == ex, "R5 control word", w1, ex);
            check(w2 == 16'h0000, "R6 no-write word", w2, 0);
          end
        end
        word_q.delete();
      end
    end
  end

  task automatic wait_drained();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input int ch);
    exp_t e;
    wait_drained();
    if (have_prev) begin
      check(rd_data == last_data, "R10 result held", rd_data, last_data);
      check(rd_err == last_err, "R10 error held", rd_err, last_err);
    end
    while (!req_ready) @(negedge clk);
    e.ch = 4'(ch);
    if (ch >= 12) begin
      e.err = 1'b1;
      e.data = last_data;
    end else begin
      e.err = 1'b0;
      e.data = sample(ch, drv_conv);
      drv_conv++;
    end
    exp_q.push_back(e);
    last_data = e.data;
    last_err = e.err;
    have_prev = 1;
    req_valid = 1'b1;
    req_chan = 4'(ch);
    @(negedge clk);
    req_valid = 1'b0;
    req_chan = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(adc_cs_n == 1'b1, "R1 cs idle in reset", adc_cs_n, 1);
    check(adc_sclk == 1'b0, "R1 sclk low in reset", adc_sclk, 0);
    rst = 1'b0;
    @(negedge clk);
    check(adc_cs_n && !adc_sclk && !adc_mosi, "R1 pins after reset",
          {adc_cs_n, adc_sclk, adc_mosi}, 3'b100);
    check(!done && req_ready, "R1 handshake after reset", {done, req_ready}, 2'b01);

    for (int c = 0; c < 12; c++) issue(c);
    issue(12);
    issue(15);
    issue(9);

    // R2: pokes while busy must be refused
    issue(2);
    repeat (30) @(negedge clk);
    check(req_ready == 1'b0, "R2 busy not ready", req_ready, 0);
    for (int i = 0; i < 3; i++) begin
      req_valid = 1'b1;
      req_chan = 4'd6;
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_drained();
    repeat (QUIET + 100) @(negedge clk);
    check(extra_done == 0 && word_q.size() == 0, "R2 busy request ignored",
          extra_done + word_q.size(), 0);

    issue(11);
    issue(0);
    wait_drained();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule